// File: doc/BRIEF.md
# Synchronous Serial Transmit Channel

The block is the transmit half of a synchronous serial port. A host writes a configuration register, a clock divider register, a one-word data buffer and a status register over a simple single-cycle register bus. Once enabled, the channel generates its own serial clock from the system clock. Each word is framed by an internal frame sync pulse lasting one serial bit period, and the word is then shifted out most significant bit first.

Two frame sync policies are available. In the data-driven policy a frame starts only when the buffer holds a word, so the line sits idle between words. In the free-running policy frames follow each other at a fixed rate. If such a frame finds the buffer empty, the frame carries zeros and a sticky underflow flag is raised. Mode and length fields are frozen while the channel runs. The divider and the data buffer stay writable at all times.

Top module: `sertx_port`

## Requirements
- R1: After hard reset every register reads 0 (configuration at address 0, divider at 1, status at 3), and ser_clk, ser_fs and ser_dat are low on the cycle after any cycle in which the channel is disabled.
- R2: A one-cycle soft_rst pulse clears the configuration (enable bit 0 included), the divider, the buffer and both status flags, as hard reset does.
- R3: Configuration layout: bit 0 is enable, bit 1 selects the free-running frame policy, and bits 7:4 hold the length field. While enable reads 1, a configuration write changes only bit 0, and bits 1 and 7:4 keep their values.
- R4: Divider writes (address 1) are accepted whether or not the channel is enabled, and ser_clk has a period of 2×(divider+1) system clocks.
- R5: A write to address 2 loads the buffer at any time and sets the full flag (status bit 0). Address 2 reads back the buffer word. The full flag clears when the word moves into the shifter at its frame sync.
- R6: With bit 1 at 0, a frame sync is issued only when the buffer is full, and no frame sync appears while it stays empty.
- R7: The word length is max(field,2)+1 bits. The low bits of the buffered word go out MSB first, one per serial clock period, in the periods right after the frame sync.
- R8: Frame sync lasts exactly one serial clock period, and ser_dat is low during that period.
- R9: With bit 1 at 1, a frame sync is issued every (length+1) serial clock periods whether or not data is waiting. A frame that finds the buffer empty sets the underflow flag (status bit 1) and shifts out zeros.
- R10: The underflow flag is sticky. Writing a 1 to status bit 1 clears it, and writing a 0 leaves it set.
- R11: The frame policy and length used for transmission are the values written together with the enable bit when the channel is switched on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 config, 1 divider, 2 buffer, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ser_clk | output | 1 | Divided serial clock, low when idle |
| ser_fs | output | 1 | Frame sync, one serial period wide |
| ser_dat | output | 1 | Serial data, changes as ser_clk rises |

## Verification
Some properties are checked on every cycle. These are the configuration lock, the quiet outputs while disabled, the full flag after a buffer write, the rule that a data-driven frame sync needs a full buffer, underflow being raised by a frame sync on an empty buffer, and underflow staying set. Other behaviour can only be shown by the bench scenarios, because each spans many serial periods. These are the serial clock period under several divider values, the decoded words across random lengths and values, the spacing of free-running frames, the zero frames after underflow, and the data-driven line staying silent once the buffer drains.

// File: rtl/sertx_port.sv
module sertx_port #(
  parameter int DIVW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        ser_clk,
  output logic        ser_fs,
  output logic        ser_dat
);
  localparam int WMAX = 16;
  localparam int BCW  = $clog2(WMAX + 1);
  localparam logic [1:0] A_CFG = 2'd0, A_DIV = 2'd1, A_BUF = 2'd2, A_STAT = 2'd3;

  logic            cfg_en, cfg_ind, act_ind;
  logic [3:0]      cfg_len, act_len;
  logic [DIVW-1:0] div_q, cnt;
  logic [WMAX-1:0] buf_q, shreg;
  logic            full, uf, in_frame;
  logic [BCW-1:0]  bitc;

  wire wr_cfg  = bus_we && bus_addr == A_CFG;
  wire wr_div  = bus_we && bus_addr == A_DIV;
  wire wr_buf  = bus_we && bus_addr == A_BUF;
  wire wr_stat = bus_we && bus_addr == A_STAT;

  wire            half      = cfg_en && cnt >= div_q;
  wire            tick      = half && !ser_clk;
  wire [BCW-1:0]  wlen      = (act_len < 4'd2) ? BCW'(3) : BCW'(act_len) + BCW'(1);
  wire [BCW-1:0]  pad       = BCW'(WMAX) - wlen;
  wire            frame_end = !in_frame || bitc == wlen;
  wire            start     = tick && frame_end && (full || act_ind);

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {8'd0, cfg_len, 2'b00, cfg_ind, cfg_en};
      A_DIV:   bus_rdata = 16'(div_q);
      A_BUF:   bus_rdata = buf_q;
      default: bus_rdata = {14'd0, uf, full};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en <= 1'b0; cfg_ind <= 1'b0; cfg_len <= '0;
      act_ind <= 1'b0; act_len <= '0; div_q <= '0;
    end else if (soft_rst) begin
      cfg_en <= 1'b0; cfg_ind <= 1'b0; cfg_len <= '0;
      act_ind <= 1'b0; act_len <= '0; div_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_en <= bus_wdata[0];
        if (!cfg_en) begin
          cfg_ind <= bus_wdata[1];
          cfg_len <= bus_wdata[7:4];
          if (bus_wdata[0]) begin
            act_ind <= bus_wdata[1];
            act_len <= bus_wdata[7:4];
          end
        end
      end
      if (wr_div) div_q <= bus_wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0; full <= 1'b0; uf <= 1'b0;
    end else if (soft_rst) begin
      buf_q <= '0; full <= 1'b0; uf <= 1'b0;
    end else begin
      if (wr_buf) buf_q <= bus_wdata;
      if (wr_buf)     full <= 1'b1;
      else if (start) full <= 1'b0;
      if (start && !full)                uf <= 1'b1;
      else if (wr_stat && bus_wdata[1])  uf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ser_clk <= 1'b0; ser_fs <= 1'b0; ser_dat <= 1'b0;
      bitc <= '0; in_frame <= 1'b0; shreg <= '0;
    end else if (soft_rst || !cfg_en) begin
      cnt <= '0; ser_clk <= 1'b0; ser_fs <= 1'b0; ser_dat <= 1'b0;
      bitc <= '0; in_frame <= 1'b0; shreg <= '0;
    end else begin
      cnt <= half ? '0 : cnt + 1'b1;
      if (half) ser_clk <= !ser_clk;
      if (tick) begin
        if (frame_end) begin
          ser_dat <= 1'b0;
          bitc    <= '0;
          if (full || act_ind) begin
            ser_fs   <= 1'b1;
            in_frame <= 1'b1;
            shreg    <= full ? (buf_q << pad) : '0;
          end else begin
            ser_fs   <= 1'b0;
            in_frame <= 1'b0;
          end
        end else begin
          ser_fs  <= 1'b0;
          ser_dat <= shreg[WMAX-1];
          shreg   <= shreg << 1;
          bitc    <= bitc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sertx_port_chk.sv
module sertx_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        ser_clk,
  input logic        ser_fs,
  input logic        ser_dat,
  input logic        cfg_en,
  input logic        cfg_ind,
  input logic [3:0]  cfg_len,
  input logic        act_ind,
  input logic        full,
  input logic        uf
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !ser_clk && !ser_fs && !ser_dat);

  a_r2_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !cfg_en && !full && !uf);

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && bus_we && bus_addr == 2'd0 && !soft_rst
    |=> cfg_ind == $past(cfg_ind) && cfg_len == $past(cfg_len));

  a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd2 && !soft_rst |=> full);

  a_r6_fs_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_fs) && !act_ind |-> $past(full));

  a_r8_fs_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_fs && ser_dat));

  a_r9_uf_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_fs) && !$past(full) |-> uf);

  a_r10_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    uf && !soft_rst && !(bus_we && bus_addr == 2'd3 && bus_wdata[1]) |=> uf);
endmodule

bind sertx_port sertx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ser_clk(ser_clk),
  .ser_fs(ser_fs), .ser_dat(ser_dat), .cfg_en(cfg_en), .cfg_ind(cfg_ind),
  .cfg_len(cfg_len), .act_ind(act_ind), .full(full), .uf(uf)
);

// File: tb/sim_sertx_port.sv
module sim_sertx_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        ser_clk, ser_fs, ser_dat;

  sertx_port u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_dat(ser_dat));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int exp_wlen = 3;
  logic [15:0] got_q[$];
  logic [15:0] acc = '0;
  int bits_left = 0, fs_cnt = 0, tick_no = 0, last_fs = 0, fs_gap = 0;
  int last_rise = 0, per = 0, fs_run = 0, fs_wide = 0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (ser_clk && !prev_sclk) begin
      tick_no++;
      per = cyc - last_rise;
      last_rise = cyc;
      if (bits_left > 0) begin
        acc = {acc[14:0], ser_dat};
        bits_left--;
        if (bits_left == 0) got_q.push_back(acc);
      end
      if (ser_fs) begin
        fs_cnt++;
        fs_run++;
        if (fs_run > 1 || ser_dat) fs_wide++;
        fs_gap = tick_no - last_fs;
        last_fs = tick_no;
        bits_left = exp_wlen;
        acc = '0;
      end else fs_run = 0;
    end
    prev_sclk = ser_clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 20000 && got_q.size() < n; i++) @(negedge clk);
  endtask

  task automatic wait_rises(input int n);
    int t0 = tick_no;
    for (int i = 0; i < 20000 && tick_no < t0 + n; i++) @(negedge clk);
  endtask

  function automatic int len_of(input int f);
    return (f < 2) ? 3 : f + 1;
  endfunction

  function automatic logic [15:0] low_bits(input logic [15:0] w, input int n);
    return w & 16'((32'd1 << n) - 1);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int f0, wl, dv;
    logic [15:0] words[3];
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(v == 16'h0, "R1 cfg reset", v, 0);
    rd(2'd1, v); check(v == 16'h0, "R1 div reset", v, 0);
    rd(2'd3, v); check(v == 16'h0, "R1 stat reset", v, 0);
    check({ser_clk, ser_fs, ser_dat} == 3'b0, "R1 idle outputs", {ser_clk, ser_fs, ser_dat}, 0);

    // R5 buffer write while disabled
    wr(2'd2, 16'hA5C3);
    rd(2'd3, v); check(v[0] == 1'b1, "R5 full after write", v[0], 1);
    rd(2'd2, v); check(v == 16'hA5C3, "R5 buffer readback", v, 16'hA5C3);

    // R6/R7/R11 data-driven single word, 8-bit length
    exp_wlen = 8; got_q.delete();
    wr(2'd0, 16'h0071);
    wait_frames(1);
    check(got_q.size() == 1, "R6 one frame sent", got_q.size(), 1);
    if (got_q.size() > 0) check(got_q[0] == 16'h00C3, "R7 word MSB first", got_q[0], 16'h00C3);
    rd(2'd3, v); check(v == 16'h0, "R5 full cleared no underflow", v, 0);
    f0 = fs_cnt;
    wait_rises(40);
    check(fs_cnt == f0, "R6 no frame sync when empty", fs_cnt, f0);

    // R3 lock while enabled
    wr(2'd0, 16'h00F3);
    rd(2'd0, v); check(v == 16'h0071, "R3 fields locked", v, 16'h0071);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check(v == 16'h0070, "R3 enable cleared fields kept", v, 16'h0070);
    repeat (2) @(negedge clk);
    check({ser_clk, ser_fs, ser_dat} == 3'b0, "R1 disabled outputs low", {ser_clk, ser_fs, ser_dat}, 0);

    // R4 divider
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0031);
    wait_rises(3);
    check(per == 6, "R4 period div2", per, 6);
    wr(2'd1, 16'd0);
    rd(2'd1, v); check(v == 16'd0, "R4 divider written while enabled", v, 0);
    wait_rises(3);
    check(per == 2, "R4 period div0", per, 2);
    wr(2'd0, 16'h0000);

    // R7 random lengths, dividers and words
    for (int it = 0; it < 6; it++) begin
      f0 = $urandom_range(15, 0);
      dv = $urandom_range(3, 0);
      wl = len_of(f0);
      for (int k = 0; k < 3; k++) words[k] = 16'($urandom());
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'(dv));
      exp_wlen = wl; got_q.delete();
      wr(2'd2, words[0]);
      wr(2'd0, 16'(f0 << 4) | 16'h0001);
      for (int k = 1; k < 3; k++) begin
        v = 16'h1;
        for (int p = 0; p < 5000 && v[0]; p++) rd(2'd3, v);
        wr(2'd2, words[k]);
      end
      wait_frames(3);
      check(got_q.size() == 3, "R7 random frame count", got_q.size(), 3);
      for (int k = 0; k < 3 && k < got_q.size(); k++)
        check(got_q[k] == low_bits(words[k], wl), "R7 random word", got_q[k], low_bits(words[k], wl));
      check(per == 2 * (dv + 1), "R4 random period", per, 2 * (dv + 1));
    end
    check(fs_wide == 0, "R8 frame sync one period, data low", fs_wide, 0);

    // R9 free-running frames on an empty buffer
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd0);
    exp_wlen = 4; got_q.delete();
    wr(2'd0, 16'h0033);
    wait_frames(3);
    check(got_q.size() >= 3, "R9 frames without data", got_q.size(), 3);
    for (int k = 0; k < 3 && k < got_q.size(); k++)
      check(got_q[k] == 16'h0, "R9 zero frame", got_q[k], 0);
    check(fs_gap == 5, "R9 frame spacing", fs_gap, 5);
    rd(2'd3, v); check(v[1] == 1'b1, "R9 underflow set", v[1], 1);
    got_q.delete();
    wr(2'd2, 16'h000B);
    wait_frames(4);
    v = 16'h0;
    foreach (got_q[k]) if (got_q[k] == 16'h000B) v = 16'h1;
    check(v == 16'h1, "R9 queued word sent", v, 1);
    check(fs_wide == 0, "R8 free-running sync width", fs_wide, 0);

    // R10 sticky underflow
    wr(2'd0, 16'h0032);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); check(v[1] == 1'b1, "R10 write 0 keeps underflow", v[1], 1);
    wr(2'd3, 16'h0002);
    rd(2'd3, v); check(v[1] == 1'b0, "R10 write 1 clears underflow", v[1], 0);

    // R2 soft reset
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h1234);
    wr(2'd0, 16'h0071);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(2'd0, v); check(v == 16'h0, "R2 cfg cleared", v, 0);
    rd(2'd1, v); check(v == 16'h0, "R2 div cleared", v, 0);
    rd(2'd3, v); check(v == 16'h0, "R2 status cleared", v, 0);
    repeat (2) @(negedge clk);
    check({ser_clk, ser_fs, ser_dat} == 3'b0, "R2 outputs low", {ser_clk, ser_fs, ser_dat}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule